// File: doc/BRIEF.md
# Transmit DMA Request Controller

This block paces an external DMA controller that fills a transmit FIFO in front of a serial protocol engine. The host writes a packet length in bytes as two byte-wide halves and then writes a command that both starts the transfer and declares that the buffer holds a whole packet. The block then requests data from the DMA controller one block at a time and counts every byte that enters the FIFO. When the count is used up it stops requesting, tells the protocol engine to close the frame with its trailer, and sets a sticky transfer-end interrupt.

The block size is the largest transfer (32 bytes by default) halved once for each step of a two-bit threshold field. A new block is opened only when the FIFO has room for all of it. Once a block is open, requests continue until the block is finished or the packet runs out, whichever comes first. Each cycle in which the request and the DMA acknowledge are both high moves one byte.

Top module: `tx_dma_req_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `dma_req`, `fifo_push`, `busy`, `frame_end` and `irq_xfer_end` are all low.
- R2: A write to address 0 loads bits 7:0 of the packet length, and a write to address 1 loads bits 15:8. A started transfer moves exactly the programmed number of bytes.
- R3: A transfer starts only on a write to address 2 with bit 0 (go) and bit 1 (message end) both set. A write with only one of these bits set leaves `busy` and `dma_req` low.
- R4: Bits 5:4 of the address-2 command select the block size: 00 gives 32, 01 gives 16, 10 gives 8 and 11 gives 4 bytes. A block opens only while `fifo_free` is at least the block size.
- R5: One byte is accepted in each cycle where `dma_req` and `dma_ack` are both high. `fifo_push` is high in exactly those cycles.
- R6: `dma_req` goes low in the cycle after the last byte is accepted, even when the current block is not finished.
- R7: After the last byte is accepted, `frame_end` is high for exactly one cycle, and `busy` is low in that same cycle.
- R8: `irq_xfer_end` is set when a transfer completes. It stays set until a write to address 3 with bit 0 set clears it. If a set and a clear happen in the same cycle, the set wins.
- R9: While `busy` is high, writes to addresses 0, 1 and 2 are ignored. Neither the byte count in progress nor the start state changes.
- R10: A start with a length of zero sets `irq_xfer_end` at the next edge. It raises no request, no push and no `frame_end`.
- R11: Lengths up to 65535 bytes are transferred in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register address (0 length low, 1 length high, 2 command, 3 interrupt clear) |
| host_wdata | input | 8 | Host write data |
| fifo_free | input | 6 | Free byte slots in the transmit FIFO |
| dma_ack | input | 1 | DMA controller presents a byte this cycle |
| dma_req | output | 1 | Request to the DMA controller |
| fifo_push | output | 1 | Byte written into the FIFO this cycle |
| busy | output | 1 | Transfer in progress |
| frame_end | output | 1 | One-cycle pulse telling the protocol engine to append its trailer |
| irq_xfer_end | output | 1 | Sticky transfer-end interrupt |

## Verification
Assertions check on every cycle that the remaining count drops by one per accepted byte and that the request falls right after the final byte. They also check that `frame_end` is a single-cycle pulse that coincides with a set interrupt and an idle engine, that the interrupt holds until it is cleared, that a zero-length start ends at once, and that the stored length does not move while a transfer runs. Only the bench scenarios can show the full behaviour. These scenarios confirm the exact byte totals for each block size, that blocks open only when the FIFO has room (using a modelled FIFO that drains slowly), that stray or busy-time writes have no effect, and that the largest length completes.

// File: rtl/tx_dma_pkg.sv
`timescale 1ns/1ps
// Package tx_dma_pkg
// Shared register addresses, command bit positions and block size helper
// for the transmit DMA request controller.
package tx_dma_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_LEN_LO = 2'd0;
    localparam logic [ADDR_W-1:0] REG_LEN_HI = 2'd1;
    localparam logic [ADDR_W-1:0] REG_CMD    = 2'd2;
    localparam logic [ADDR_W-1:0] REG_IRQ    = 2'd3;

    localparam int CMD_GO_BIT  = 0;
    localparam int CMD_EOM_BIT = 1;
    localparam int CMD_THR_LSB = 4;

    // Block size in bytes for a threshold selector: the largest block halved per step.
    function automatic int unsigned blk_of(input logic [1:0] sel, input int unsigned max_blk);
        return max_blk >> sel;
    endfunction
endpackage

// File: rtl/tx_dma_regs.sv
`timescale 1ns/1ps
// Module tx_dma_regs
// Host-facing registers: holds the packet length written as two halves and
// decodes the start command and the interrupt clear strobe.
// Assumes DATA_W < CNT_W <= 2*DATA_W. All writes except the interrupt clear
// are ignored while busy is high.
module tx_dma_regs #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [tx_dma_pkg::ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic                           busy,
    output logic [CNT_W-1:0]               pkt_len,
    output logic [1:0]                     go_thr,
    output logic                           go_pulse,
    output logic                           irq_clr
);
    import tx_dma_pkg::*;

    localparam int HI_W = CNT_W - DATA_W;

    logic wr_ok;

    // Host writes count only while no transfer is running.
    always_comb wr_ok = wr_en && !busy;

    // Decode the start command, its block-size selector and the interrupt clear.
    always_comb begin
        go_pulse = wr_ok && (addr == REG_CMD) && wdata[CMD_GO_BIT] && wdata[CMD_EOM_BIT];
        go_thr   = wdata[CMD_THR_LSB +: 2];
        irq_clr  = wr_en && (addr == REG_IRQ) && wdata[0];
    end

    // Store the packet length halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_len <= '0;
        end else if (wr_ok) begin
            if (addr == REG_LEN_LO) pkt_len[DATA_W-1:0]     <= wdata;
            if (addr == REG_LEN_HI) pkt_len[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
        end
    end

    // R9
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(pkt_len));
endmodule

// File: rtl/tx_dma_engine.sv
`timescale 1ns/1ps
// Module tx_dma_engine
// Counts the bytes still owed for the packet, opens blocks only when the FIFO
// can hold a whole block, issues the DMA request and signals the frame end.
// Assumes fifo_free only drops through this block's own pushes, so an opened
// block always fits.
module tx_dma_engine #(
    parameter int CNT_W   = 16,
    parameter int FREE_W  = 6,
    parameter int MAX_BLK = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CNT_W-1:0]  go_len,
    input  logic [1:0]        go_thr,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic              dma_ack,
    output logic              dma_req,
    output logic              fifo_push,
    output logic              busy,
    output logic              frame_end,
    output logic              xfer_done
);
    localparam int BLK_W = $clog2(MAX_BLK + 1);

    logic              active;
    logic [CNT_W-1:0]  rem;
    logic [BLK_W-1:0]  blk_size;
    logic [BLK_W-1:0]  blk_left;
    logic              blk_open;
    logic              room;
    logic              accept;
    logic              last;

    // Request while bytes remain and either a block is open or a new one fits.
    always_comb begin
        blk_open  = (blk_left != '0);
        room      = 32'(fifo_free) >= 32'(blk_size);
        dma_req   = active && (rem != '0) && (blk_open || room);
        accept    = dma_req && dma_ack;
        last      = accept && (rem == CNT_W'(1));
        fifo_push = accept;
        xfer_done = last || (go && !active && (go_len == '0));
        busy      = active;
    end

    // Load a new transfer, then step the packet and block counters per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            rem       <= '0;
            blk_size  <= '0;
            blk_left  <= '0;
            frame_end <= 1'b0;
        end else begin
            frame_end <= last;
            if (go && !active) begin
                if (go_len != '0) begin
                    active   <= 1'b1;
                    rem      <= go_len;
                    blk_size <= BLK_W'(tx_dma_pkg::blk_of(go_thr, MAX_BLK));
                    blk_left <= '0;
                end
            end else if (accept) begin
                rem      <= rem - CNT_W'(1);
                blk_left <= (blk_open ? blk_left : blk_size) - BLK_W'(1);
                if (last) begin
                    active   <= 1'b0;
                    blk_left <= '0;
                end
            end
        end
    end

    // R2
    rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !last) |=> (rem == $past(rem) - CNT_W'(1)));

    // R6
    req_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !dma_req);

    // R7
    frame_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R4
    blk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_left <= blk_size);
endmodule

// File: rtl/tx_dma_req_ctrl.sv
`timescale 1ns/1ps
// Module tx_dma_req_ctrl (top)
// Transmit DMA request controller: the host programs a length and starts the
// transfer, the engine paces the DMA controller in blocks, and a sticky
// interrupt marks the end of each transfer.
// Assumes the FIFO reports its free space in bytes every cycle.
module tx_dma_req_ctrl #(
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 32,
    parameter int MAX_BLK    = 32,
    parameter int FREE_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_wr,
    input  logic [tx_dma_pkg::ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]             host_wdata,
    input  logic [FREE_W-1:0]             fifo_free,
    input  logic                          dma_ack,
    output logic                          dma_req,
    output logic                          fifo_push,
    output logic                          busy,
    output logic                          frame_end,
    output logic                          irq_xfer_end
);
    logic [CNT_W-1:0] pkt_len;
    logic [1:0]       go_thr;
    logic             go_pulse;
    logic             irq_clr;
    logic             xfer_done;

    tx_dma_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .busy     (busy),
        .pkt_len  (pkt_len),
        .go_thr   (go_thr),
        .go_pulse (go_pulse),
        .irq_clr  (irq_clr)
    );

    tx_dma_engine #(.CNT_W(CNT_W), .FREE_W(FREE_W), .MAX_BLK(MAX_BLK)) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_pulse),
        .go_len    (pkt_len),
        .go_thr    (go_thr),
        .fifo_free (fifo_free),
        .dma_ack   (dma_ack),
        .dma_req   (dma_req),
        .fifo_push (fifo_push),
        .busy      (busy),
        .frame_end (frame_end),
        .xfer_done (xfer_done)
    );

    // Sticky end-of-transfer flag: set on completion, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_xfer_end <= 1'b0;
        else if (xfer_done) irq_xfer_end <= 1'b1;
        else if (irq_clr)   irq_xfer_end <= 1'b0;
    end

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_xfer_end && !irq_clr) |=> irq_xfer_end);

    // R7
    frame_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (irq_xfer_end && !busy));

    // R10
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_pulse && pkt_len == '0) |=> (!busy && irq_xfer_end && !frame_end));

    // R1
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dma_req);
endmodule

// File: tb/tx_dma_req_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for tx_dma_req_ctrl: a vector table of transfers walked by one loop
// against a modelled draining FIFO, then directed reset and corner tests.
module tx_dma_req_ctrl_tb_top;
    localparam int DEPTH  = 32;
    localparam int FREE_W = $clog2(DEPTH + 1);
    localparam int NVEC   = 7;
    localparam int WD_LIMIT = 190000;

    // {length[31:16], thr[15:14], alternate ack[13], pad[12:8], drain period[7:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'd5,   2'd3, 1'b0, 5'd0, 8'd1},
        {16'd40,  2'd0, 1'b0, 5'd0, 8'd3},
        {16'd17,  2'd1, 1'b1, 5'd0, 8'd2},
        {16'd1,   2'd2, 1'b0, 5'd0, 8'd1},
        {16'd300, 2'd2, 1'b1, 5'd0, 8'd4},
        {16'd64,  2'd3, 1'b0, 5'd0, 8'd7},
        {16'd40,  2'd0, 1'b0, 5'd0, 8'd50}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              host_wr;
    logic [1:0]        host_addr;
    logic [7:0]        host_wdata;
    logic [FREE_W-1:0] fifo_free;
    logic              dma_ack;
    logic              dma_req, fifo_push, busy, frame_end, irq_xfer_end;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int occ   = 0;

    always #2 clk = ~clk;

    tx_dma_req_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .fifo_free(fifo_free), .dma_ack(dma_ack),
        .dma_req(dma_req), .fifo_push(fifo_push), .busy(busy),
        .frame_end(frame_end), .irq_xfer_end(irq_xfer_end)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WD_LIMIT) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
                summary_and_end();
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic program_len(input int len, input int thr);
        wr(2'd0, len[7:0]);
        wr(2'd1, len[15:8]);
        wr(2'd2, 8'h03 | 8'(thr << 4));
    endtask

    // Feed the DMA until the transfer ends; check count, block rule, end signalling.
    task automatic stream(input int exp_len, input int thr, input bit alt,
                          input int drain, input string tag);
        int pushes = 0;
        int blk_left = 0;
        int blk_bad = 0;
        int fe_seen = 0;
        int blk = 32 >> thr;
        int t = 0;
        bit ended = 0;
        while (!ended && t < 100000) begin
            @(negedge clk);
            if (frame_end) fe_seen++;
            if (!busy) begin
                ended = 1;
                chk(frame_end == 1'b1, {"R7 frame_end at completion ", tag}, frame_end, 1);
            end else begin
                t++;
                if (occ > 0 && (t % drain) == 0) occ--;
                fifo_free = FREE_W'(DEPTH - occ);
                dma_ack   = alt ? t[0] : 1'b1;
                #0.5;
                if (dma_req && dma_ack) begin
                    if (blk_left == 0) begin
                        if (DEPTH - occ < blk) blk_bad++;
                        blk_left = blk;
                    end
                    blk_left--;
                    pushes++;
                    occ++;
                end
            end
        end
        dma_ack = 1'b0;
        #0.5;
        chk(pushes == exp_len, {"R2 R5 byte total ", tag}, pushes, exp_len);
        chk(dma_req == 1'b0, {"R6 request low after last byte ", tag}, dma_req, 0);
        chk(blk_bad == 0, {"R4 block opened only with room ", tag}, blk_bad, 0);
        chk(irq_xfer_end == 1'b1, {"R8 interrupt set ", tag}, irq_xfer_end, 1);
        @(negedge clk);
        chk(frame_end == 1'b0 && fe_seen == 1, {"R7 single frame_end pulse ", tag},
            fe_seen + int'(frame_end), 1);
        occ = 0;
        fifo_free = FREE_W'(DEPTH);
    endtask

    initial begin
        rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
        fifo_free = FREE_W'(DEPTH); dma_ack = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!dma_req && !fifo_push && !busy && !frame_end && !irq_xfer_end,
            "R1 reset outputs low", {dma_req, fifo_push, busy, frame_end, irq_xfer_end}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !irq_xfer_end, "R1 idle after reset", {busy, irq_xfer_end}, 0);

        // Vector table walk: R2 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            program_len(int'(VEC[i][31:16]), int'(VEC[i][15:14]));
            stream(int'(VEC[i][31:16]), int'(VEC[i][15:14]), VEC[i][13],
                   int'(VEC[i][7:0]), $sformatf("vec%0d", i));
            wr(2'd3, 8'h01);
            chk(irq_xfer_end == 1'b0, "R8 write-one clears interrupt", irq_xfer_end, 0);
        end

        // R3: incomplete start commands are ignored
        wr(2'd0, 8'd6); wr(2'd1, 8'd0);
        wr(2'd2, 8'h01);
        chk(!busy && !dma_req, "R3 go without message end", {busy, dma_req}, 0);
        wr(2'd2, 8'h02);
        chk(!busy && !dma_req, "R3 message end without go", {busy, dma_req}, 0);

        // R8: writing zero to the clear bit keeps the flag
        program_len(2, 3);
        stream(2, 3, 1'b0, 1, "r8_pre");
        wr(2'd3, 8'h00);
        chk(irq_xfer_end == 1'b1, "R8 zero write keeps interrupt", irq_xfer_end, 1);
        wr(2'd3, 8'h01);

        // R9: writes during a transfer are ignored
        program_len(10, 1);
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd1);
        wr(2'd2, 8'h33);
        stream(10, 1, 1'b0, 1, "r9_busy_writes");
        wr(2'd3, 8'h01);

        // R10: zero length start
        program_len(0, 0);
        chk(irq_xfer_end && !busy && !dma_req && !frame_end, "R10 zero length ends at once",
            {irq_xfer_end, busy, dma_req, frame_end}, 8);
        wr(2'd3, 8'h01);

        // R11: largest length
        program_len(65535, 3);
        stream(65535, 3, 1'b0, 1, "r11_max");

        summary_and_end();
    end
endmodule